// File: doc/BRIEF.md
# Grouped Digital I/O Port with Edge Interrupt Status

This block is an eight-line digital I/O port on a 16-bit register bus. The eight lines are split into a low group (lines 0 to 3) and a high group (lines 4 to 7). One direction bit per group makes all four of its lines outputs. The output values come from the low byte of the control register, and a read of that register returns the pin levels after they pass through a synchroniser.

Lines whose group is an input are watched for edges. Each of lines 0 to 3 has its own polarity bit, and lines 4 to 7 share one. A detected edge sets one bit in an interrupt status register. That register also collects seven generic request inputs from other parts of the chip. Status bits are cleared by writing 1. A single interrupt output is high while any pending status bit has its enable set.

The bus is a plain single-cycle register port. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. There is no stream interface, so no valid/ready handshake is involved.

Top module: `grouped_gpio_irq`

## Requirements
- R1: After reset all lines are inputs (`pin_oe` = 0x00), both edge selections are rising, the status and enable registers read 0x0000, and `irq_out` is low.
- R2: Control bit 10 drives `pin_oe[3:0]` and control bit 11 drives `pin_oe[7:4]` (1 = output), starting from the edge that writes them. Control bits 7:0 drive `pin_out[7:0]`.
- R3: A read of the control register (address 0) returns the pin levels in bits 7:0, seen two clocks after they change. Bits 15:8 return the stored control bits, and bit 9 always reads 0.
- R4: For line i in 0..3, control bit 12+i selects the edge (1 = falling, 0 = rising). A selected edge on an input line sets status bit 8+i.
- R5: Control bit 8 selects the edge for lines 4..7 together (1 = falling, 0 = rising). A selected edge on line j sets status bit 8+j.
- R6: An edge on a line whose group is configured as output sets no status bit.
- R7: A high `src_req[k]` in a clock cycle sets status bit k, for k = 0..6. Status bit 7 always reads 0.
- R8: Writing the status register (address 2) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R9: If a new event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: The enable register (address 1) reads back what was written. `irq_out` is the OR over all bits of status AND enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 enable, 2 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| pin_in | input | 8 | Pin levels as seen at the pads |
| pin_out | output | 8 | Output values for the lines |
| pin_oe | output | 8 | Output enable per line, set per group of four |
| src_req | input | 7 | Event requests from other sources, one per status bit 0..6 |
| irq_out | output | 1 | Interrupt request |

## Verification
The assertions check these on every cycle:
- the group enables follow the last control write;
- output-group lines never raise an edge event;
- any event, from a pin or a request input, is visible in status on the next cycle even when a clear hits it;
- a clear with no competing event empties the written bits;
- the interrupt is never high without a pending bit or with all enables off.

The bench's scenarios are needed for the rest:
- the polarity choice per line and per group;
- the two-cycle synchroniser latency in the readback;
- which status bit each line and each request lands on;
- that bits written as 0 survive a status write.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 2;
  localparam int LINES     = 8;
  localparam int GRP_SIZE  = 4;
  localparam int GROUPS    = LINES / GRP_SIZE;
  localparam int SRC_N     = 7;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  // control field positions
  localparam int B_HI_FALL = 8;   // shared polarity, high group
  localparam int B_DIR0    = 10;  // direction, group 0 (group g at B_DIR0+g)
  localparam int B_LO_FALL = 12;  // per-line polarity, low group
  localparam int B_PIN_EVT = 8;   // first status bit of pin events

  // bit 9 is not implemented; bits 7:0 on read come from pins
  localparam logic [DATA_W-1:0] CTRL_RD_MASK = 16'hFD00;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
`timescale 1ns/1ps
module gpio_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,      // synchronised levels
  input  logic [W-1:0] fall_sel, // 1 = falling, 0 = rising
  input  logic [W-1:0] in_en,    // line is an input
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    logic rise, fall;
    assign rise   = lvl[i] & ~prev_q[i];
    assign fall   = ~lvl[i] & prev_q[i];
    assign evt[i] = in_en[i] & (fall_sel[i] ? fall : rise);
  end
endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
module gpio_irq_status #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_q
);
  // a new event takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_i) | set_i;
  end
endmodule

// File: rtl/grouped_gpio_irq.sv
`timescale 1ns/1ps
module grouped_gpio_irq
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe,
  input  logic [SRC_N-1:0]  src_req,
  output logic              irq_out
);
  logic [DATA_W-1:0] ctrl_q, ien_q, status_q, set_vec, clr_vec;
  logic [LINES-1:0]  lvl_sync, fall_sel, pin_evt;
  logic              wr_ctrl, wr_ien, wr_stat;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_ien  = reg_wr && (reg_addr == A_IEN);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (wr_ien)  ien_q  <= reg_wdata;
    end
  end

  assign pin_out = ctrl_q[LINES-1:0];

  for (genvar g = 0; g < GROUPS; g++) begin : g_dir
    assign pin_oe[g*GRP_SIZE +: GRP_SIZE] = {GRP_SIZE{ctrl_q[B_DIR0+g]}};
  end

  for (genvar i = 0; i < LINES; i++) begin : g_pol
    if (i < GRP_SIZE) begin : g_own
      assign fall_sel[i] = ctrl_q[B_LO_FALL+i];
    end else begin : g_shared
      assign fall_sel[i] = ctrl_q[B_HI_FALL];
    end
  end

  gpio_in_sync #(.W(LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
  );

  gpio_edge_det #(.W(LINES)) i_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_sync),
    .fall_sel(fall_sel), .in_en(~pin_oe), .evt(pin_evt)
  );

  assign set_vec = {pin_evt, 1'b0, src_req};
  assign clr_vec = wr_stat ? reg_wdata : '0;

  gpio_irq_status #(.W(DATA_W)) i_stat (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec),
    .stat_q(status_q)
  );

  assign irq_out = |(status_q & ien_q);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = (ctrl_q & CTRL_RD_MASK) | {{(DATA_W-LINES){1'b0}}, lvl_sync};
      A_IEN:   reg_rdata = ien_q;
      A_STAT:  reg_rdata = status_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/grouped_gpio_irq_checker.sv
`timescale 1ns/1ps
module grouped_gpio_irq_checker
  import gpio_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [LINES-1:0]  pin_oe,
  input logic [SRC_N-1:0]  src_req,
  input logic              irq_out,
  input logic [DATA_W-1:0] stat,
  input logic [DATA_W-1:0] ien,
  input logic [DATA_W-1:0] evt
);
  AST_OE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL) |=> pin_oe == {{4{$past(reg_wdata[11])}}, {4{$past(reg_wdata[10])}}}); // R2

  AST_OUT_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[15:8] & pin_oe) == 8'h00); // R6

  AST_SRC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_req) |=> ((stat[SRC_N-1:0] & $past(src_req)) == $past(src_req))); // R7

  AST_W1C_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && evt == 16'h0) |=> ((stat & $past(reg_wdata)) == 16'h0)); // R8

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat & $past(evt)) == $past(evt))); // R9

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (stat != 16'h0)); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 16'h0) |-> !irq_out); // R10
endmodule

bind grouped_gpio_irq grouped_gpio_irq_checker i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pin_oe(pin_oe), .src_req(src_req),
  .irq_out(irq_out), .stat(status_q), .ien(ien_q), .evt(set_vec)
);

// File: tb/test_grouped_gpio_irq.sv
`timescale 1ns/1ps
module test_grouped_gpio_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [7:0]  pin_in, pin_out, pin_oe, ext;
  logic [6:0]  src_req = 7'h0;
  logic        irq_out;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk; // 50 MHz

  // pad model: driven lines reflect the output value
  initial ext = 8'h00;
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  grouped_gpio_irq i_grouped_gpio_irq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .src_req(src_req), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_ext(input logic [7:0] v);
    @(negedge clk);
    ext = v;
    settle();
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); chk("R1 ctrl", d, 16'h0000);
    rd(2'd1, d); chk("R1 ien", d, 16'h0000);
    rd(2'd2, d); chk("R1 stat", d, 16'h0000);
    chk("R1 oe", {8'h0, pin_oe}, 16'h0000);
    chk("R1 irq", {15'h0, irq_out}, 16'h0000);
  endtask

  task automatic t_direction();
    logic [15:0] d;
    wr(2'd0, 16'h04A5);
    chk("R2 oe low group", {8'h0, pin_oe}, 16'h000F);
    chk("R2 out", {8'h0, pin_out}, 16'h00A5);
    settle();
    rd(2'd0, d); chk("R3 readback low driven", d, 16'h0405);
    wr(2'd0, 16'h0B00); // high group out, bit9 and bit8 set
    chk("R2 oe high group", {8'h0, pin_oe}, 16'h00F0);
    settle();
    rd(2'd0, d); chk("R3 bit9 reads 0", d, 16'h0900);
    wr(2'd0, 16'h0000);
    set_ext(8'h3C);
    rd(2'd0, d); chk("R3 input levels", d, 16'h003C);
    set_ext(8'h00);
    wr(2'd2, 16'hFFFF);
  endtask

  task automatic t_low_polarity();
    logic [15:0] d;
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'hFFFF);
    set_ext(8'h01);
    rd(2'd2, d); chk("R4 rising line0", d, 16'h0100);
    wr(2'd2, 16'hFFFF);
    set_ext(8'h00);
    rd(2'd2, d); chk("R4 falling ignored when rising", d, 16'h0000);
    wr(2'd0, 16'h2000); // line1 falling
    set_ext(8'h02);
    rd(2'd2, d); chk("R4 rising ignored when falling", d, 16'h0000);
    set_ext(8'h00);
    rd(2'd2, d); chk("R4 falling line1", d, 16'h0200);
    wr(2'd2, 16'hFFFF);
  endtask

  task automatic t_high_polarity();
    logic [15:0] d;
    wr(2'd0, 16'h0000);
    set_ext(8'h20);
    rd(2'd2, d); chk("R5 rising line5", d, 16'h2000);
    wr(2'd2, 16'hFFFF);
    wr(2'd0, 16'h0100); // shared falling
    set_ext(8'hE0);     // 6 and 7 rise: ignored
    rd(2'd2, d); chk("R5 rising ignored", d, 16'h0000);
    set_ext(8'h00);     // 5,6,7 fall
    rd(2'd2, d); chk("R5 falling lines 5-7", d, 16'hE000);
    wr(2'd2, 16'hFFFF);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_out_mask();
    logic [15:0] d;
    wr(2'd0, 16'h0400);
    settle();
    wr(2'd0, 16'h0404); // line2 driven high
    settle();
    rd(2'd2, d); chk("R6 driven edge ignored", d, 16'h0000);
    wr(2'd0, 16'h0400);
    settle();
    wr(2'd0, 16'h0000);
    settle();
    wr(2'd2, 16'hFFFF);
  endtask

  task automatic t_src();
    logic [15:0] d;
    @(negedge clk); src_req = 7'h48;
    @(negedge clk); src_req = 7'h00;
    rd(2'd2, d); chk("R7 sources 3 and 6", d, 16'h0048);
    wr(2'd2, 16'hFFFF);
    @(negedge clk); src_req = 7'h7F;
    @(negedge clk); src_req = 7'h00;
    rd(2'd2, d); chk("R7 all sources, bit7 zero", d, 16'h007F);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    wr(2'd2, 16'h0000);
    rd(2'd2, d); chk("R8 write 0 keeps", d, 16'h007F);
    wr(2'd2, 16'h0005);
    rd(2'd2, d); chk("R8 write 1 clears", d, 16'h007A);
    wr(2'd2, 16'hFFFF);
    rd(2'd2, d); chk("R8 clear all", d, 16'h0000);
  endtask

  task automatic t_race();
    logic [15:0] d;
    @(negedge clk); src_req = 7'h01;
    @(negedge clk); src_req = 7'h00;
    @(negedge clk);
    src_req = 7'h01; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0003;
    @(negedge clk);
    src_req = 7'h00; reg_wr = 1'b0;
    rd(2'd2, d); chk("R9 event wins over clear", d, 16'h0001);
    wr(2'd2, 16'hFFFF);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    wr(2'd1, 16'h0104);
    rd(2'd1, d); chk("R10 enable readback", d, 16'h0104);
    chk("R10 irq idle", {15'h0, irq_out}, 16'h0000);
    @(negedge clk); src_req = 7'h02;
    @(negedge clk); src_req = 7'h00;
    #1 chk("R10 irq not enabled", {15'h0, irq_out}, 16'h0000);
    set_ext(8'h01);
    #1 chk("R10 irq line0", {15'h0, irq_out}, 16'h0001);
    wr(2'd2, 16'h0100);
    #1 chk("R10 irq after clear", {15'h0, irq_out}, 16'h0000);
    @(negedge clk); src_req = 7'h04;
    @(negedge clk); src_req = 7'h00;
    #1 chk("R10 irq source2", {15'h0, irq_out}, 16'h0001);
    wr(2'd1, 16'h0000);
    #1 chk("R10 irq disabled", {15'h0, irq_out}, 16'h0000);
    set_ext(8'h00);
    wr(2'd2, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_low_polarity();
    t_high_polarity();
    t_out_mask();
    t_src();
    t_w1c();
    t_race();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule